// File: doc/BRIEF.md
# Auto-Reload Wakeup Down-Counter

This block produces a periodic wakeup event from a slow time base. The slow clock appears as a single-cycle tick strobe in the fast clock domain. While the timer runs, a prescaler divides those ticks by an amount set by a clock-select code. Each divided tick steps a down-counter. When the counter is at zero, the next divided tick loads it again from the reload value and sets a sticky event flag. An interrupt output follows that flag.

Software changes the reload value or the clock select with a fixed handshake:

1. Clear the run bit.
2. Poll the write-allowed flag until it is set. The flag rises only after a programmable number of slow ticks, which models the synchronisation delay into the slow domain.
3. Program the new values.
4. Set the run bit again. The count restarts from the reload value.

Writes that arrive outside this window are dropped.

Top module: `wkup_timer`

## Requirements
- R1: After reset the timer is stopped (run_o=0), wr_ok_o=1, flag_o=0, irq_o=0, and count_o, reload_o and sel_o are all zero.
- R2: A reload write (reload_we_i) takes effect on the next clock edge only if run_o=0 and wr_ok_o=1 at that edge. Otherwise reload_o keeps its value.
- R3: A clock-select write (sel_we_i) is gated in the same way as R2. A refused write leaves sel_o unchanged.
- R4: wr_ok_o goes to 0 on the same edge that sets run_o, and it stays 0 for as long as run_o=1.
- R5: After run_o clears, wr_ok_o rises on the edge that consumes the SYNC_TICKS-th tick_i pulse (default 2). Pulses that arrive while running, or in the cycle of the clearing write, are not counted.
- R6: Setting run_o from 0 to 1 loads count_o with reload_o and restarts the prescaler phase at zero.
- R7: Clock-select codes 0, 1, 2 and 3 divide tick_i by 16, 8, 4 and 2 respectively. Codes 4 to 7 pass every tick through undivided.
- R8: Each divided tick lowers count_o by one. A divided tick that finds count_o at 0 reloads it from reload_o and sets flag_o on the same edge. From enable to the first event therefore takes (reload+1)*divisor ticks.
- R9: flag_o stays at 1 until flag_clr_i is asserted. If a clear and a new event fall on the same edge, the event wins.
- R10: irq_o equals flag_o at all times.
- R11: While run_o=0, count_o and the prescaler phase hold their values whatever happens on tick_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per slow-clock period |
| run_we_i | input | 1 | Write strobe for the run bit |
| run_i | input | 1 | New run bit value |
| reload_we_i | input | 1 | Write strobe for the reload value |
| reload_i | input | RELOAD_W | New reload value |
| sel_we_i | input | 1 | Write strobe for the clock select |
| sel_i | input | 3 | New clock-select code |
| flag_clr_i | input | 1 | Clears the event flag |
| run_o | output | 1 | Current run bit |
| wr_ok_o | output | 1 | Reconfiguration allowed |
| reload_o | output | RELOAD_W | Current reload value |
| sel_o | output | 3 | Current clock select |
| count_o | output | RELOAD_W | Current down-counter value |
| flag_o | output | 1 | Sticky wakeup event flag |
| irq_o | output | 1 | Interrupt, follows the flag |

## Verification
The bench builds the block with its default parameters: a 16-bit reload value and a two-tick write-allowed delay. At that delay, every step of the handshake takes only a few cycles, so the handshake can be repeated thousands of times in one run. Random reload values are mostly kept below eight, so full periods complete even at divide-by-16. A few values are drawn across the whole 16-bit range, which exercises holds and restarts in the middle of a count. Directed runs measure the time to the first event for every divisor class, including a code above 3.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned PRESC_W = 4;

  // last prescaler phase before a divided tick; 0 means undivided
  function automatic logic [PRESC_W-1:0] presc_last(input logic [SEL_W-1:0] sel);
    logic [PRESC_W-1:0] last;
    case (sel)
      3'd0:    last = 4'd15;
      3'd1:    last = 4'd7;
      3'd2:    last = 4'd3;
      3'd3:    last = 4'd1;
      default: last = 4'd0;
    endcase
    return last;
  endfunction
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
  parameter int unsigned SYNC_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_q_i,
  input  logic start_i,
  input  logic tick_i,
  output logic wr_ok_o
);
  localparam int unsigned CW = (SYNC_TICKS < 2) ? 1 : $clog2(SYNC_TICKS);
  localparam logic [CW-1:0] LAST = CW'(SYNC_TICKS - 1);

  logic [CW-1:0] sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ok_o <= 1'b1;
      sc_q    <= '0;
    end else if (run_q_i || start_i) begin
      wr_ok_o <= 1'b0;
      sc_q    <= '0;
    end else if (!wr_ok_o && tick_i) begin
      if (sc_q == LAST) begin
        wr_ok_o <= 1'b1;
        sc_q    <= '0;
      end else begin
        sc_q <= sc_q + 1'b1;
      end
    end
  end

  p_ok_low_running_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q_i |-> !wr_ok_o);
  p_ok_rise_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_ok_o) |-> $past(tick_i && !run_q_i));
endmodule

// File: rtl/wkup_presc.sv
module wkup_presc
  import wkup_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_q_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ce_o
);
  logic [PRESC_W-1:0] ph_q;
  logic [PRESC_W-1:0] last;

  assign last = presc_last(sel_i);
  assign ce_o = run_q_i && tick_i && (ph_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ph_q <= '0;
    else if (start_i)           ph_q <= '0;
    else if (run_q_i && tick_i) ph_q <= ce_o ? '0 : ph_q + 1'b1;
  end

  p_phase_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q_i |-> ph_q <= last);
  p_phase_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q_i && !start_i) |=> $stable(ph_q));
endmodule

// File: rtl/wkup_core.sv
module wkup_core #(
  parameter int unsigned RELOAD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_q_i,
  input  logic                start_i,
  input  logic                ce_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                clr_i,
  output logic [RELOAD_W-1:0] cnt_o,
  output logic                flag_o
);
  logic expire;
  assign expire = run_q_i && ce_i && (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (start_i)           cnt_o <= reload_i;
    else if (run_q_i && ce_i)   cnt_o <= (cnt_o == '0) ? reload_i : cnt_o - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (expire) flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  p_reload_at_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q_i && ce_i && cnt_o == '0 && !start_i) |=> (flag_o && cnt_o == $past(reload_i)));
  p_count_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q_i && !start_i) |=> $stable(cnt_o));
  p_flag_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(run_q_i && ce_i && cnt_o == '0)) |=> !flag_o);
  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/wkup_timer.sv
module wkup_timer
  import wkup_pkg::*;
#(
  parameter int unsigned RELOAD_W   = 16,
  parameter int unsigned SYNC_TICKS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                run_we_i,
  input  logic                run_i,
  input  logic                reload_we_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                sel_we_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                flag_clr_i,
  output logic                run_o,
  output logic                wr_ok_o,
  output logic [RELOAD_W-1:0] reload_o,
  output logic [SEL_W-1:0]    sel_o,
  output logic [RELOAD_W-1:0] count_o,
  output logic                flag_o,
  output logic                irq_o
);
  logic start, cfg_open, ce;

  assign start    = run_we_i && run_i && !run_o;
  assign cfg_open = !run_o && wr_ok_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_o <= 1'b0;
    else if (run_we_i) run_o <= run_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_o <= '0;
      sel_o    <= '0;
    end else begin
      if (reload_we_i && cfg_open) reload_o <= reload_i;
      if (sel_we_i && cfg_open)    sel_o    <= sel_i;
    end
  end

  wkup_sync #(.SYNC_TICKS(SYNC_TICKS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_q_i(run_o), .start_i(start),
    .tick_i(tick_i), .wr_ok_o(wr_ok_o)
  );

  wkup_presc u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_q_i(run_o), .start_i(start),
    .tick_i(tick_i), .sel_i(sel_o), .ce_o(ce)
  );

  wkup_core #(.RELOAD_W(RELOAD_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_q_i(run_o), .start_i(start),
    .ce_i(ce), .reload_i(reload_o), .clr_i(flag_clr_i),
    .cnt_o(count_o), .flag_o(flag_o)
  );

  assign irq_o = flag_o;

  p_reload_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_o != $past(reload_o)) |-> $past(reload_we_i && !run_o && wr_ok_o));
  p_sel_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != $past(sel_o)) |-> $past(sel_we_i && !run_o && wr_ok_o));
  p_start_loads_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (count_o == $past(reload_o)));
endmodule

// File: tb/wkup_timer_tb_top.sv
`timescale 1ns/1ps
module wkup_timer_tb_top;
  localparam int RW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, run_we = 0, run = 0, rel_we = 0, sel_we = 0, clr = 0;
  logic [RW-1:0] rel = '0;
  logic [2:0] sel = '0;
  logic run_o, ok_o, flag_o, irq_o;
  logic [RW-1:0] rel_o, cnt_o;
  logic [2:0] sel_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wkup_timer #(.RELOAD_W(RW), .SYNC_TICKS(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_we_i(run_we), .run_i(run),
    .reload_we_i(rel_we), .reload_i(rel), .sel_we_i(sel_we), .sel_i(sel),
    .flag_clr_i(clr), .run_o(run_o), .wr_ok_o(ok_o), .reload_o(rel_o),
    .sel_o(sel_o), .count_o(cnt_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int divisor(input logic [2:0] s);
    return (s >= 3'd4) ? 1 : (16 >> s);
  endfunction

  // reference model built from the requirements
  logic m_run, m_ok, m_flag;
  logic [RW-1:0] m_rel, m_cnt;
  logic [2:0] m_sel;
  int m_ph, m_sc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_ok = 1; m_flag = 0; m_rel = '0; m_cnt = '0; m_sel = '0; m_ph = 0; m_sc = 0;
    end else begin
      bit st, open, dt, ev;
      st = run_we && run && !m_run;
      open = !m_run && m_ok;
      dt = m_run && tick && (m_ph == divisor(m_sel) - 1);
      ev = 0;
      if (st) begin
        m_cnt = m_rel; m_ph = 0;
      end else if (m_run && tick) begin
        m_ph = dt ? 0 : m_ph + 1;
        if (dt) begin
          if (m_cnt == 0) begin m_cnt = m_rel; ev = 1; end
          else m_cnt = m_cnt - 1;
        end
      end
      if (ev) m_flag = 1; else if (clr) m_flag = 0;
      if (m_run || st) begin m_ok = 0; m_sc = 0; end
      else if (!m_ok && tick) begin
        if (m_sc == 1) begin m_ok = 1; m_sc = 0; end else m_sc++;
      end
      if (rel_we && open) m_rel = rel;
      if (sel_we && open) m_sel = sel;
      if (run_we) m_run = run;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 run", run_o, m_run);
      chk("R5 wr_ok", ok_o, m_ok);
      chk("R2 reload", rel_o, m_rel);
      chk("R3 sel", sel_o, m_sel);
      chk("R8 count", cnt_o, m_cnt);
      chk("R9 flag", flag_o, m_flag);
      chk("R10 irq", irq_o, flag_o);
    end
  end

  task automatic drive(input bit t, input bit rwe, input bit r, input bit lwe,
                       input logic [RW-1:0] l, input bit swe, input logic [2:0] s, input bit c);
    @(negedge clk);
    tick = t; run_we = rwe; run = r; rel_we = lwe; rel = l; sel_we = swe; sel = s; clr = c;
  endtask

  task automatic idle(input int n, input bit t);
    for (int i = 0; i < n; i++) drive(t, 0, 0, 0, '0, 0, 3'd0, 0);
  endtask

  task automatic run_period(input logic [2:0] s, input logic [RW-1:0] l);
    int n;
    drive(0, 1, 0, 0, '0, 0, 3'd0, 0);
    idle(3, 1);
    drive(0, 0, 0, 1, l, 1, s, 1);
    drive(0, 1, 1, 0, '0, 0, 3'd0, 0);
    drive(1, 0, 0, 0, '0, 0, 3'd0, 0);
    n = 0;
    while (n < 400) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (flag_o) break;
    end
    chk("R7 R8 period", n, (int'(l) + 1) * divisor(s));
    chk("R10 irq on event", irq_o, 1);
    tick = 0; clr = 1;
    @(negedge clk);
    chk("R9 flag cleared", flag_o, 0);
    clr = 0;
  endtask

  initial begin
    logic [RW-1:0] held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 run", run_o, 0);   chk("R1 wr_ok", ok_o, 1);
    chk("R1 flag", flag_o, 0); chk("R1 irq", irq_o, 0);
    chk("R1 count", cnt_o, 0); chk("R1 reload", rel_o, 0); chk("R1 sel", sel_o, 0);

    drive(0, 0, 0, 1, 16'd5, 1, 3'd3, 0);
    drive(0, 0, 0, 0, '0, 0, 3'd0, 0);
    chk("R2 reload accepted", rel_o, 5);
    chk("R3 sel accepted", sel_o, 3);
    drive(0, 1, 1, 0, '0, 0, 3'd0, 0);
    drive(0, 0, 0, 0, '0, 0, 3'd0, 0);
    chk("R4 run set", run_o, 1);
    chk("R4 wr_ok cleared", ok_o, 0);
    chk("R6 count loaded", cnt_o, 5);
    drive(0, 0, 0, 1, 16'd9, 1, 3'd1, 0);
    drive(0, 0, 0, 0, '0, 0, 3'd0, 0);
    chk("R2 reload refused while running", rel_o, 5);
    chk("R3 sel refused while running", sel_o, 3);
    drive(1, 0, 0, 0, '0, 0, 3'd0, 0);
    drive(1, 1, 0, 0, '0, 0, 3'd0, 0);
    drive(0, 0, 0, 1, 16'd7, 0, 3'd0, 0);
    drive(0, 0, 0, 0, '0, 0, 3'd0, 0);
    held = cnt_o;
    chk("R2 reload refused before wr_ok", rel_o, 5);
    chk("R5 wr_ok still low", ok_o, 0);
    drive(1, 0, 0, 0, '0, 0, 3'd0, 0);
    drive(0, 0, 0, 0, '0, 0, 3'd0, 0);
    chk("R5 wr_ok low after one tick", ok_o, 0);
    drive(1, 0, 0, 0, '0, 0, 3'd0, 0);
    drive(0, 0, 0, 0, '0, 0, 3'd0, 0);
    chk("R5 wr_ok high after two ticks", ok_o, 1);
    idle(10, 1);
    chk("R11 count held while stopped", cnt_o, held);

    run_period(3'd0, 16'd2);
    run_period(3'd1, 16'd3);
    run_period(3'd2, 16'd0);
    run_period(3'd3, 16'd5);
    run_period(3'd4, 16'd6);
    run_period(3'd7, 16'd1);

    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      tick   = ($urandom % 3) != 0;
      run_we = ($urandom % 200) == 0;
      run    = ($urandom % 4) != 0;
      rel_we = ($urandom % 8) == 0;
      rel    = (($urandom % 16) == 0) ? RW'($urandom) : RW'($urandom % 6);
      sel_we = ($urandom % 8) == 0;
      sel    = 3'($urandom);
      clr    = ($urandom % 24) == 0;
    end
    idle(2, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done = 1;
    errors++; checks++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule